// File: doc/BRIEF.md
# Windowed Address Mapper

This block turns two kinds of processor address into a physical target, a segment number and a byte offset. Data accesses arrive as a 16-bit address. The lower half of that space is local data RAM and the top quarter is an I/O area. The quarter between them is a 16 KB window. A data map register steers the window either onto instruction memory or onto one 16 KB slice of a 128 KB unified-memory segment.

Instruction fetches arrive as a word PC, which becomes a byte address when multiplied by four. One byte-address bit chooses which of two fetch map registers is used. The chosen register sends the fetch either straight to instruction memory or into a unified segment.

A per-segment presence mask marks which unified segments exist. An access to a missing segment raises a bus error, and so does any I/O address outside the small set of legal registers. Both translations are combinational. The three map registers are loaded on the clock edge from a shared write-data bus, each through its own enable.

Top module: `seg_addr_xlate`

## Requirements
- R1: A data address with bit 15 clear (0x0000..0x7FFF) gives target DRAM (code 0), offset equal to the address, segment 0, and no bus error.
- R2: A data address at 0xC000 or above gives target IO (code 1), offset equal to the address and segment 0. The bus error is raised unless the address lies in 0xFF00..0xFF0F.
- R3: A data address in 0x8000..0xBFFF while data map bit 12 is set gives target IMEM (code 2) and offset map[3:0]*0x4000 + address[13:0], with no bus error.
- R4: A data address in 0x8000..0xBFFF while data map bit 12 is clear gives target UMEM (code 3), segment map[9:3] and offset map[2:0]*0x4000 + address[13:0]. Map bits 15:13 and 11:10 have no effect.
- R5: The fetch byte address is PC*4 (18 bits for a 16-bit PC). Its bit 17 selects the second fetch map, and a clear bit 17 selects the first.
- R6: When the selected fetch map has bit 12 set, the fetch target is IMEM (code 2) with offset equal to the byte address, segment 0 and no bus error.
- R7: When the selected fetch map has bit 12 clear, the fetch target is UMEM (code 3), the segment output is map[6:0] and the offset is the byte address masked to 17 bits. If map bit 7 is set, the segment is out of range and the bus error is raised.
- R8: A UMEM access from either path whose segment bit in seg_present is 0 raises the bus error.
- R9: After reset, both fetch maps hold 0x1000 and the data map holds 0x0000.
- R10: A map register loads map_wdata on a rising clock edge only when its own write enable is high. The other registers keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the map registers |
| rst_n | input | 1 | Active-low synchronous reset |
| map_wdata | input | 16 | Write data shared by the three map registers |
| dmap_we | input | 1 | Load enable for the data map |
| imap0_we | input | 1 | Load enable for fetch map 0 |
| imap1_we | input | 1 | Load enable for fetch map 1 |
| seg_present | input | 128 | One bit per unified segment, 1 = present |
| daddr | input | 16 | Data address |
| pc | input | 16 | Word program counter |
| d_tgt | output | 2 | Data target: 0 DRAM, 1 IO, 2 IMEM, 3 UMEM |
| d_seg | output | 7 | Data unified segment (0 when target is not UMEM) |
| d_off | output | 18 | Data physical offset |
| d_berr | output | 1 | Data bus error |
| f_tgt | output | 2 | Fetch target, same coding as d_tgt |
| f_seg | output | 7 | Fetch unified segment (0 when target is not UMEM) |
| f_off | output | 18 | Fetch physical offset |
| f_berr | output | 1 | Fetch bus error |

## Verification
A change on daddr, pc or seg_present reaches the outputs in the same cycle with no register in between. The bench therefore drives these inputs just after a falling edge and samples a couple of nanoseconds later, before the next rising edge. A map write takes effect on the rising edge where its enable is high. The bench drops the enable at the following falling edge and only then samples, so every check after a write sees the new register value. The reset checks sample in the first low clock phase after reset is released.

// File: rtl/sax_pkg.sv
package sax_pkg;
  parameter int DAW    = 16;
  parameter int PCW    = 16;
  parameter int MAPW   = 16;
  parameter int SEGW   = 7;
  parameter int WINW   = 14;
  parameter int UOFFW  = 17;
  localparam int NSEG  = 1 << SEGW;
  localparam int OFFW  = PCW + 2;
  localparam int SLW   = UOFFW - WINW;
  localparam int IBW   = OFFW - WINW;
  localparam int MAP_IMEM_BIT = 12;
  localparam int SEG_RANGE_BIT = SEGW;
  localparam logic [DAW-5:0] IO_OK_HI = 12'hFF0;
  localparam logic [MAPW-1:0] IMAP_RST = 16'h1000;
  localparam logic [MAPW-1:0] DMAP_RST = 16'h0000;

  typedef enum logic [1:0] {
    TGT_DRAM = 2'd0,
    TGT_IO   = 2'd1,
    TGT_IMEM = 2'd2,
    TGT_UMEM = 2'd3
  } tgt_e;

  typedef struct packed {
    tgt_e            tgt;
    logic [SEGW-1:0] seg;
    logic [OFFW-1:0] off;
    logic            err;
  } xres_t;

  function automatic xres_t map_data(input logic [DAW-1:0] a,
                                     input logic [MAPW-1:0] m,
                                     input logic [NSEG-1:0] pres);
    xres_t r;
    r = '0;
    if (!a[DAW-1]) begin
      r.tgt = TGT_DRAM;
      r.off = OFFW'(a);
    end else if (a[DAW-2]) begin
      r.tgt = TGT_IO;
      r.off = OFFW'(a);
      r.err = (a[DAW-1:4] != IO_OK_HI);
    end else if (m[MAP_IMEM_BIT]) begin
      r.tgt = TGT_IMEM;
      r.off = {m[IBW-1:0], a[WINW-1:0]};
    end else begin
      r.tgt = TGT_UMEM;
      r.seg = m[SLW +: SEGW];
      r.off = OFFW'({m[SLW-1:0], a[WINW-1:0]});
      r.err = !pres[m[SLW +: SEGW]];
    end
    return r;
  endfunction

  function automatic xres_t map_fetch(input logic [PCW-1:0] pc,
                                      input logic [MAPW-1:0] m0,
                                      input logic [MAPW-1:0] m1,
                                      input logic [NSEG-1:0] pres);
    xres_t r;
    logic [OFFW-1:0] b;
    logic [MAPW-1:0] m;
    r = '0;
    b = {pc, 2'b00};
    m = b[OFFW-1] ? m1 : m0;
    if (m[MAP_IMEM_BIT]) begin
      r.tgt = TGT_IMEM;
      r.off = b;
    end else begin
      r.tgt = TGT_UMEM;
      r.seg = m[SEGW-1:0];
      r.off = OFFW'(b[UOFFW-1:0]);
      r.err = m[SEG_RANGE_BIT] || !pres[m[SEGW-1:0]];
    end
    return r;
  endfunction
endpackage

// File: rtl/sax_map_reg.sv
module sax_map_reg #(
  parameter int W = 16,
  parameter logic [W-1:0] RSTV = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n)  q <= RSTV;
    else if (we) q <= d;
  end

  a_r9_reset_value: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> q == RSTV);
  a_r10_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(q));
  a_r10_load: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> q == $past(d));
endmodule

// File: rtl/sax_data_xlate.sv
module sax_data_xlate
  import sax_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [DAW-1:0]  daddr,
  input  logic [MAPW-1:0] dmap,
  input  logic [NSEG-1:0] pres,
  output xres_t           res
);
  logic in_low, in_io, in_win, io_legal;

  assign res      = map_data(daddr, dmap, pres);
  assign in_low   = (daddr < 16'h8000);
  assign in_io    = (daddr >= 16'hC000);
  assign in_win   = !in_low && !in_io;
  assign io_legal = (daddr >= 16'hFF00) && (daddr <= 16'hFF0F);

  a_r1_low_dram: assert property (@(posedge clk) disable iff (!rst_n)
    in_low |-> res.tgt == TGT_DRAM && !res.err && res.off[DAW-1:0] == daddr);
  a_r2_io_err: assert property (@(posedge clk) disable iff (!rst_n)
    in_io |-> res.tgt == TGT_IO && res.err == !io_legal);
  a_r3_imem_win: assert property (@(posedge clk) disable iff (!rst_n)
    (in_win && dmap[MAP_IMEM_BIT]) |-> res.tgt == TGT_IMEM && !res.err
      && res.off == (OFFW'(dmap[3:0]) * 18'h4000 + OFFW'(daddr[WINW-1:0])));
  a_r4_umem_win: assert property (@(posedge clk) disable iff (!rst_n)
    (in_win && !dmap[MAP_IMEM_BIT]) |-> res.tgt == TGT_UMEM
      && res.off == (OFFW'(dmap[2:0]) * 18'h4000 + OFFW'(daddr[WINW-1:0])));
  a_r8_data_absent: assert property (@(posedge clk) disable iff (!rst_n)
    (res.tgt == TGT_UMEM && !pres[res.seg]) |-> res.err);
endmodule

// File: rtl/sax_fetch_xlate.sv
module sax_fetch_xlate
  import sax_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PCW-1:0]  pc,
  input  logic [MAPW-1:0] imap0,
  input  logic [MAPW-1:0] imap1,
  input  logic [NSEG-1:0] pres,
  output xres_t           res
);
  logic [OFFW-1:0] byte_addr;
  logic            hi_half;
  logic [MAPW-1:0] sel_map;

  assign res       = map_fetch(pc, imap0, imap1, pres);
  assign byte_addr = OFFW'(pc) * 4;
  assign hi_half   = (byte_addr >= 18'h20000);
  assign sel_map   = hi_half ? imap1 : imap0;

  a_r6_imem_fetch: assert property (@(posedge clk) disable iff (!rst_n)
    res.tgt == TGT_IMEM |-> res.off == byte_addr && !res.err && sel_map[MAP_IMEM_BIT]);
  a_r7_umem_fetch: assert property (@(posedge clk) disable iff (!rst_n)
    res.tgt == TGT_UMEM |-> res.off == (byte_addr % 18'h20000) && res.seg == sel_map[SEGW-1:0]);
  a_r7_range_err: assert property (@(posedge clk) disable iff (!rst_n)
    (res.tgt == TGT_UMEM && sel_map[SEG_RANGE_BIT]) |-> res.err);
  a_r8_fetch_absent: assert property (@(posedge clk) disable iff (!rst_n)
    (res.tgt == TGT_UMEM && !pres[res.seg]) |-> res.err);
  a_r5_two_targets: assert property (@(posedge clk) disable iff (!rst_n)
    res.tgt == TGT_IMEM || res.tgt == TGT_UMEM);
endmodule

// File: rtl/seg_addr_xlate.sv
module seg_addr_xlate
  import sax_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [15:0]     map_wdata,
  input  logic            dmap_we,
  input  logic            imap0_we,
  input  logic            imap1_we,
  input  logic [127:0]    seg_present,
  input  logic [15:0]     daddr,
  input  logic [15:0]     pc,
  output logic [1:0]      d_tgt,
  output logic [6:0]      d_seg,
  output logic [17:0]     d_off,
  output logic            d_berr,
  output logic [1:0]      f_tgt,
  output logic [6:0]      f_seg,
  output logic [17:0]     f_off,
  output logic            f_berr
);
  localparam int NMAP = 3;

  logic [NMAP-1:0] map_we;
  logic [MAPW-1:0] map_q [NMAP];
  xres_t           d_res, f_res;

  assign map_we = {imap1_we, imap0_we, dmap_we};

  for (genvar g = 0; g < NMAP; g++) begin : g_map
    localparam logic [MAPW-1:0] RV = (g == 0) ? DMAP_RST : IMAP_RST;
    sax_map_reg #(.W(MAPW), .RSTV(RV)) u_reg (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (map_we[g]),
      .d     (map_wdata),
      .q     (map_q[g])
    );
  end

  sax_data_xlate u_data (
    .clk   (clk),
    .rst_n (rst_n),
    .daddr (daddr),
    .dmap  (map_q[0]),
    .pres  (seg_present),
    .res   (d_res)
  );

  sax_fetch_xlate u_fetch (
    .clk   (clk),
    .rst_n (rst_n),
    .pc    (pc),
    .imap0 (map_q[1]),
    .imap1 (map_q[2]),
    .pres  (seg_present),
    .res   (f_res)
  );

  assign d_tgt  = d_res.tgt;
  assign d_seg  = d_res.seg;
  assign d_off  = d_res.off;
  assign d_berr = d_res.err;
  assign f_tgt  = f_res.tgt;
  assign f_seg  = f_res.seg;
  assign f_off  = f_res.off;
  assign f_berr = f_res.err;

  a_r8_err_only_io_umem: assert property (@(posedge clk) disable iff (!rst_n)
    (d_berr |-> (d_tgt == TGT_IO || d_tgt == TGT_UMEM)));
  a_r1_seg_zero_off_umem: assert property (@(posedge clk) disable iff (!rst_n)
    (d_tgt != TGT_UMEM) |-> d_seg == '0);
endmodule

// File: tb/tb_seg_addr_xlate.sv
module tb_seg_addr_xlate;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [15:0]  map_wdata = '0;
  logic         dmap_we = 1'b0, imap0_we = 1'b0, imap1_we = 1'b0;
  logic [127:0] seg_present;
  logic [15:0]  daddr = '0;
  logic [15:0]  pc = '0;
  logic [1:0]   d_tgt, f_tgt;
  logic [6:0]   d_seg, f_seg;
  logic [17:0]  d_off, f_off;
  logic         d_berr, f_berr;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  seg_addr_xlate dut (
    .clk(clk), .rst_n(rst_n), .map_wdata(map_wdata),
    .dmap_we(dmap_we), .imap0_we(imap0_we), .imap1_we(imap1_we),
    .seg_present(seg_present), .daddr(daddr), .pc(pc),
    .d_tgt(d_tgt), .d_seg(d_seg), .d_off(d_off), .d_berr(d_berr),
    .f_tgt(f_tgt), .f_seg(f_seg), .f_off(f_off), .f_berr(f_berr)
  );

  // {dmap, daddr, target, segment, offset, bus error}
  localparam int NV = 13;
  localparam logic [59:0] VEC [NV] = '{
    {16'h0000, 16'h1234, 2'd0, 7'd0,  18'h01234, 1'b0}, // R1
    {16'h0000, 16'h7FFF, 2'd0, 7'd0,  18'h07FFF, 1'b0}, // R1
    {16'h0000, 16'hFF00, 2'd1, 7'd0,  18'h0FF00, 1'b0}, // R2
    {16'h0000, 16'hFF0F, 2'd1, 7'd0,  18'h0FF0F, 1'b0}, // R2
    {16'h0000, 16'hFF10, 2'd1, 7'd0,  18'h0FF10, 1'b1}, // R2
    {16'h0000, 16'hC000, 2'd1, 7'd0,  18'h0C000, 1'b1}, // R2
    {16'h0000, 16'hFEFF, 2'd1, 7'd0,  18'h0FEFF, 1'b1}, // R2
    {16'h100A, 16'h8123, 2'd2, 7'd0,  18'h28123, 1'b0}, // R3
    {16'h100F, 16'hBFFF, 2'd2, 7'd0,  18'h3FFFF, 1'b0}, // R3
    {16'h0033, 16'h9001, 2'd3, 7'd6,  18'h0D001, 1'b0}, // R4
    {16'h02AF, 16'hBFFE, 2'd3, 7'd85, 18'h1FFFE, 1'b0}, // R4
    {16'h002A, 16'h8000, 2'd3, 7'd5,  18'h08000, 1'b1}, // R8
    {16'hE030, 16'h8004, 2'd3, 7'd6,  18'h00004, 1'b0}  // R4
  };

  task automatic check(input string req, input bit fetch, input logic [1:0] et,
                       input logic [6:0] es, input logic [17:0] eo, input logic ee);
    logic [1:0] at; logic [6:0] as_; logic [17:0] ao; logic ae;
    at  = fetch ? f_tgt : d_tgt;
    as_ = fetch ? f_seg : d_seg;
    ao  = fetch ? f_off : d_off;
    ae  = fetch ? f_berr : d_berr;
    n_chk++;
    if (at !== et || as_ !== es || ao !== eo || ae !== ee) begin
      n_bad++;
      $display("FAIL %s %s: got tgt=%0d seg=%0d off=%h err=%b, want tgt=%0d seg=%0d off=%h err=%b",
               req, fetch ? "fetch" : "data", at, as_, ao, ae, et, es, eo, ee);
    end
  endtask

  // drives at a falling edge, load on the next rising edge, returns at the falling edge after it
  task automatic write_map(input int which, input logic [15:0] v);
    @(negedge clk);
    map_wdata = v;
    dmap_we  = (which == 0);
    imap0_we = (which == 1);
    imap1_we = (which == 2);
    @(negedge clk);
    dmap_we = 1'b0; imap0_we = 1'b0; imap1_we = 1'b0;
  endtask

  task automatic settle;
    #2;
  endtask

  task automatic do_reset;
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    seg_present = '1;
    seg_present[5] = 1'b0;
    seg_present[100] = 1'b0;
    do_reset();

    // R9: data map resets to 0 -> window goes to unified segment 0, slice 0
    daddr = 16'h8010; pc = 16'h0000; settle();
    check("R9", 1'b0, 2'd3, 7'd0, 18'h00010, 1'b0);
    // R9: both fetch maps reset to 0x1000 -> instruction memory
    check("R9", 1'b1, 2'd2, 7'd0, 18'h00000, 1'b0);
    pc = 16'h8000; settle();
    check("R9", 1'b1, 2'd2, 7'd0, 18'h20000, 1'b0);

    for (int i = 0; i < NV; i++) begin
      write_map(0, VEC[i][59:44]);
      daddr = VEC[i][43:28]; settle();
      check($sformatf("vector %0d (R1/R2/R3/R4/R8)", i), 1'b0,
            VEC[i][27:26], VEC[i][25:19], VEC[i][18:1], VEC[i][0]);
    end

    // R7/R5: first fetch map points at unified segment 18
    write_map(1, 16'h0012);
    pc = 16'h0123; settle();
    check("R7", 1'b1, 2'd3, 7'd18, 18'h0048C, 1'b0);
    // R5/R6: byte bit 17 set selects second map (still 0x1000)
    pc = 16'h8001; settle();
    check("R5", 1'b1, 2'd2, 7'd0, 18'h20004, 1'b0);
    // R8/R7: second map -> absent segment 100, offset masked to 17 bits
    write_map(2, 16'h0064);
    pc = 16'hFFFF; settle();
    check("R8", 1'b1, 2'd3, 7'd100, 18'h1FFFC, 1'b1);
    // R7: map bit 7 set -> out-of-range segment, error
    write_map(1, 16'h0085);
    pc = 16'h0001; settle();
    check("R7", 1'b1, 2'd3, 7'd5, 18'h00004, 1'b1);
    // R8: same segment present once mask changes
    seg_present[5] = 1'b1; settle();
    check("R7", 1'b1, 2'd3, 7'd5, 18'h00004, 1'b1);
    write_map(1, 16'h0005); settle();
    check("R8", 1'b1, 2'd3, 7'd5, 18'h00004, 1'b0);
    seg_present[5] = 1'b0;

    // R10: data map holds 0xE030 from the table; a write to fetch map 0 leaves it alone
    write_map(1, 16'h1000);
    daddr = 16'h8004; pc = 16'h0002; settle();
    check("R10", 1'b0, 2'd3, 7'd6, 18'h00004, 1'b0);
    check("R10", 1'b1, 2'd2, 7'd0, 18'h00008, 1'b0);
    // R10: data written with no enable has no effect
    @(negedge clk); map_wdata = 16'h100C;
    @(negedge clk); settle();
    check("R10", 1'b0, 2'd3, 7'd6, 18'h00004, 1'b0);

    // R9: reset again mid-run restores all maps
    do_reset();
    daddr = 16'h8010; pc = 16'hFFFF; settle();
    check("R9", 1'b0, 2'd3, 7'd0, 18'h00010, 1'b0);
    check("R9", 1'b1, 2'd2, 7'd0, 18'h3FFFC, 1'b0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout, want completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule